// File: doc/BRIEF.md
# Hashed Exact-Match Lookup Table

This block is an exact-match key-to-response table whose entries live in a RAM array, not in per-entry registers with their own comparators. A key presented on the lookup port is folded into a bucket number. The bucket, which holds several entries side by side in one RAM row, is read in a single cycle, and its entries are compared with the key in parallel. Three clock edges after the request is accepted, the block returns a result with a hit flag and, on a hit, the response stored with the matching key. A new lookup can be accepted on every cycle.

A small management port adds, updates and removes entries without any software. The block chooses the slot for each entry itself. An insert of a key that is already present overwrites its response. A new key takes the lowest-numbered free way of its bucket. An insert into a bucket that is already full is refused. Because placement depends on the hash, a table cannot always be filled to its physical depth. Plan for about 95% of the slots.

Control is a four-state machine.
- `ST_SWEEP` is entered from reset. It writes every bucket row to all-invalid, one row per cycle, and moves to `ST_IDLE` after the last row.
- In `ST_IDLE` a management request is accepted. The machine goes to `ST_READ` on a request and otherwise stays in `ST_IDLE`.
- `ST_READ` reads the bucket of the captured key. It always moves to `ST_WRITE`.
- `ST_WRITE` decides the outcome, writes the row back and blocks lookups for this one cycle. It always returns to `ST_IDLE`.

Top module: `hash_lut`

## Requirements
- R1: In the first cycle after reset is released, `res_valid`, `mgmt_ready` and `lkp_ready` are low. A sweep then clears every bucket. `mgmt_ready` rises exactly DEPTH/WAYS clock edges after reset is released (64 with the defaults), and after that every lookup misses.
- R2: A lookup is accepted at a rising edge where `lkp_valid` and `lkp_ready` are both high. Its result appears with `res_valid` high after exactly three rising edges, counting the accepting edge. Requests on consecutive cycles give results on consecutive cycles, in the same order.
- R3: `res_hit` is 1 when the key equals the key of a valid stored entry, and then `res_resp` carries that entry's response. On a miss, `res_hit` is 0 and `res_resp` is 0.
- R4: An insert (`mgmt_op`=0) of a key that is not stored puts the entry into the lowest-numbered free way of its bucket and reports status 0. A way freed by a delete can be used again.
- R5: An insert of a key that is already stored replaces its response in place and reports status 1. No second copy is made, so a single delete removes the key.
- R6: An insert of a new key into a bucket whose WAYS ways are all valid reports status 3 and leaves the table unchanged.
- R7: A delete (`mgmt_op`=1) of a stored key clears it and reports status 2. Later lookups of that key miss.
- R8: A delete of a key that is not stored reports status 3 and leaves the table unchanged.
- R9: `mgmt_ready` is high only in `ST_IDLE`. A request is accepted at a rising edge where `mgmt_req` and `mgmt_ready` are both high. `mgmt_done` is high for exactly one cycle, after the third rising edge counting the accepting edge, with `mgmt_status` valid in that cycle. A lookup accepted in or after that cycle sees the new contents.
- R10: The bucket number is the XOR of the key split into 6-bit chunks, least significant first, with the top chunk zero-padded. With a 16-bit key it is key[5:0] ^ key[11:6] ^ {2'b00, key[15:12]}.
- R11: `lkp_ready` is low during the one `ST_WRITE` cycle of each management operation. A lookup offered while `lkp_ready` is low produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and the RAM |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request present |
| lkp_key | input | KEY_W | Key to look up |
| lkp_ready | output | 1 | Lookup can be accepted this cycle |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Key was found |
| res_resp | output | RESP_W | Stored response on a hit, 0 on a miss |
| mgmt_req | input | 1 | Management request present |
| mgmt_op | input | 1 | 0 insert, 1 delete |
| mgmt_key | input | KEY_W | Key to insert or delete |
| mgmt_resp | input | RESP_W | Response to store on insert |
| mgmt_ready | output | 1 | Management request can be accepted |
| mgmt_done | output | 1 | One-cycle completion pulse |
| mgmt_status | output | 2 | 0 added, 1 updated, 2 removed, 3 refused |

## Verification
A wrong bucket row shows up as a wrong hit flag or a wrong response on the very next lookup of an affected key, three cycles after that lookup is issued. A wrong placement or a missed duplicate check stays hidden until a bucket fills or a key is deleted. It then shows as a wrong status 3, or as a key that still hits after its delete. For that reason the bench fills one bucket on purpose, and it runs a long random mix of inserts and deletes against a model of every bucket. A control-state error shows within one operation: the ready, done and lookup-blocking cycles are checked against fixed offsets from acceptance.

// File: rtl/hash_lut_pkg.sv
package hash_lut_pkg;

    typedef enum logic [1:0] {
        ST_SWEEP = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } ctl_state_e;

    typedef enum logic [1:0] {
        STS_ADDED   = 2'd0,
        STS_UPDATED = 2'd1,
        STS_REMOVED = 2'd2,
        STS_REFUSED = 2'd3
    } mgmt_status_e;

    localparam logic OP_INSERT = 1'b0;
    localparam logic OP_DELETE = 1'b1;

endpackage

// File: rtl/hash_lut_hash.sv
module hash_lut_hash #(
    parameter int KEY_W = 16,
    parameter int IDX_W = 6
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);
    localparam int CHUNKS = (KEY_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] acc;

    assign padded = PAD_W'(key);

    always_comb begin
        acc = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            acc = acc ^ padded[c*IDX_W +: IDX_W];
        end
    end

    assign idx = acc;
endmodule

// File: rtl/hash_lut_store.sv
module hash_lut_store #(
    parameter int ROW_W   = 100,
    parameter int BUCKETS = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [ROW_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [ROW_W-1:0] rd_b_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ROW_W-1:0] wr_data
);
    logic [ROW_W-1:0] mem [BUCKETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        rd_a_data <= mem[rd_a_idx];
        rd_b_data <= mem[rd_b_idx];
    end
endmodule

// File: rtl/hash_lut_ctrl.sv
module hash_lut_ctrl
    import hash_lut_pkg::*;
#(
    parameter int KEY_W   = 16,
    parameter int RESP_W  = 8,
    parameter int WAYS    = 4,
    parameter int BUCKETS = 64,
    parameter int IDX_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mgmt_req,
    input  logic                     mgmt_op,
    input  logic [KEY_W-1:0]         mgmt_key,
    input  logic [RESP_W-1:0]        mgmt_resp,
    output logic                     mgmt_ready,
    output logic                     mgmt_done,
    output logic [1:0]               mgmt_status,
    output logic                     lkp_ready,
    output logic [KEY_W-1:0]         m_key,
    input  logic [IDX_W-1:0]         m_idx,
    input  logic [WAYS*(KEY_W+RESP_W+1)-1:0] row_in,
    output logic                     wr_en,
    output logic [IDX_W-1:0]         wr_idx,
    output logic [WAYS*(KEY_W+RESP_W+1)-1:0] wr_data
);
    localparam int ENT_W = KEY_W + RESP_W + 1;
    localparam int ROW_W = WAYS * ENT_W;
    localparam int WAY_W = $clog2(WAYS);

    ctl_state_e       state_q, state_d;
    logic [IDX_W-1:0] sweep_q;
    logic             op_q;
    logic [KEY_W-1:0] key_q;
    logic [RESP_W-1:0] resp_q;
    logic             sweep_last;

    logic             hit_found, free_found;
    logic [WAY_W-1:0] hit_way, free_way;
    logic [ENT_W-1:0] ent;
    logic [ROW_W-1:0] dec_row;
    mgmt_status_e     dec_sts;

    assign m_key      = key_q;
    assign sweep_last = (sweep_q == IDX_W'(BUCKETS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SWEEP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (sweep_last) state_d = ST_IDLE;
            ST_IDLE:  if (mgmt_req)   state_d = ST_READ;
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
        endcase
    end

    // sweep counter and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_q <= '0;
            op_q    <= OP_INSERT;
            key_q   <= '0;
            resp_q  <= '0;
        end else begin
            if (state_q == ST_SWEEP) sweep_q <= sweep_q + 1'b1;
            if (state_q == ST_IDLE && mgmt_req) begin
                op_q   <= mgmt_op;
                key_q  <= mgmt_key;
                resp_q <= mgmt_resp;
            end
        end
    end

    // bucket decision: lowest matching way, lowest free way
    always_comb begin
        hit_found  = 1'b0;
        free_found = 1'b0;
        hit_way    = '0;
        free_way   = '0;
        ent        = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            ent = row_in[w*ENT_W +: ENT_W];
            if (ent[ENT_W-1] && ent[ENT_W-2 -: KEY_W] == key_q) begin
                hit_found = 1'b1;
                hit_way   = WAY_W'(w);
            end
            if (!ent[ENT_W-1]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
        dec_row = row_in;
        dec_sts = STS_REFUSED;
        if (op_q == OP_INSERT) begin
            if (hit_found) begin
                dec_row[int'(hit_way)*ENT_W +: ENT_W] = {1'b1, key_q, resp_q};
                dec_sts = STS_UPDATED;
            end else if (free_found) begin
                dec_row[int'(free_way)*ENT_W +: ENT_W] = {1'b1, key_q, resp_q};
                dec_sts = STS_ADDED;
            end
        end else if (hit_found) begin
            dec_row[int'(hit_way)*ENT_W +: ENT_W] = '0;
            dec_sts = STS_REMOVED;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgmt_done   <= 1'b0;
            mgmt_status <= 2'd0;
        end else begin
            mgmt_done <= (state_q == ST_WRITE);
            if (state_q == ST_WRITE) mgmt_status <= dec_sts;
        end
    end

    assign mgmt_ready = (state_q == ST_IDLE);
    assign lkp_ready  = (state_q == ST_IDLE) || (state_q == ST_READ);
    assign wr_en      = (state_q == ST_SWEEP) ||
                        (state_q == ST_WRITE && dec_sts != STS_REFUSED);
    assign wr_idx     = (state_q == ST_SWEEP) ? sweep_q : m_idx;
    assign wr_data    = (state_q == ST_SWEEP) ? '0 : dec_row;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_done |=> !mgmt_done);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_req && mgmt_ready) |=> !mgmt_ready);

    // R6 R8
    refused_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_done && mgmt_status == 2'd3) |-> $past(!wr_en));

    // R1
    sweep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |-> (!lkp_ready && !mgmt_ready));
endmodule

// File: rtl/hash_lut.sv
module hash_lut #(
    parameter int KEY_W  = 16,
    parameter int RESP_W = 8,
    parameter int DEPTH  = 256,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [KEY_W-1:0]  lkp_key,
    output logic              lkp_ready,
    output logic              res_valid,
    output logic              res_hit,
    output logic [RESP_W-1:0] res_resp,
    input  logic              mgmt_req,
    input  logic              mgmt_op,
    input  logic [KEY_W-1:0]  mgmt_key,
    input  logic [RESP_W-1:0] mgmt_resp,
    output logic              mgmt_ready,
    output logic              mgmt_done,
    output logic [1:0]        mgmt_status
);
    localparam int BUCKETS = DEPTH / WAYS;
    localparam int IDX_W   = $clog2(BUCKETS);
    localparam int ENT_W   = KEY_W + RESP_W + 1;
    localparam int ROW_W   = WAYS * ENT_W;

    logic [IDX_W-1:0]  lkp_idx, m_idx, s1_idx, wr_idx;
    logic [KEY_W-1:0]  m_key, s1_key, s2_key;
    logic              s1_vld, s2_vld, wr_en;
    logic [ROW_W-1:0]  s2_row, m_row, wr_data;
    logic              cmp_hit;
    logic [RESP_W-1:0] cmp_resp;
    logic [ENT_W-1:0]  cmp_ent;

    hash_lut_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash_lkp (
        .key(lkp_key), .idx(lkp_idx));

    hash_lut_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash_mgmt (
        .key(m_key), .idx(m_idx));

    hash_lut_store #(.ROW_W(ROW_W), .BUCKETS(BUCKETS), .IDX_W(IDX_W)) u_store (
        .clk(clk),
        .rd_a_idx(s1_idx), .rd_a_data(s2_row),
        .rd_b_idx(m_idx),  .rd_b_data(m_row),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

    hash_lut_ctrl #(.KEY_W(KEY_W), .RESP_W(RESP_W), .WAYS(WAYS),
                    .BUCKETS(BUCKETS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mgmt_req(mgmt_req), .mgmt_op(mgmt_op), .mgmt_key(mgmt_key),
        .mgmt_resp(mgmt_resp), .mgmt_ready(mgmt_ready), .mgmt_done(mgmt_done),
        .mgmt_status(mgmt_status), .lkp_ready(lkp_ready),
        .m_key(m_key), .m_idx(m_idx), .row_in(m_row),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

    // stage 1: hash
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_key <= '0;
            s1_idx <= '0;
        end else begin
            s1_vld <= lkp_valid && lkp_ready;
            s1_key <= lkp_key;
            s1_idx <= lkp_idx;
        end
    end

    // stage 2: RAM read (row registered inside the store)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            s2_key <= '0;
        end else begin
            s2_vld <= s1_vld;
            s2_key <= s1_key;
        end
    end

    // stage 3: parallel compare over the ways
    always_comb begin
        cmp_hit  = 1'b0;
        cmp_resp = '0;
        cmp_ent  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            cmp_ent = s2_row[w*ENT_W +: ENT_W];
            if (cmp_ent[ENT_W-1] && cmp_ent[ENT_W-2 -: KEY_W] == s2_key) begin
                cmp_hit  = 1'b1;
                cmp_resp = cmp_ent[RESP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_resp  <= '0;
        end else begin
            res_valid <= s2_vld;
            res_hit   <= s2_vld && cmp_hit;
            res_resp  <= (s2_vld && cmp_hit) ? cmp_resp : '0;
        end
    end

    // R2
    lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(lkp_valid && lkp_ready, 3));

    // R3
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && res_resp == '0));
endmodule

// File: tb/hash_lut_tb.sv
module hash_lut_tb;
    localparam int CLK_P   = 10;
    localparam int KEY_W   = 16;
    localparam int RESP_W  = 8;
    localparam int DEPTH   = 256;
    localparam int WAYS    = 4;
    localparam int BUCKETS = DEPTH / WAYS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lkp_valid = 1'b0;
    logic [KEY_W-1:0] lkp_key = '0;
    logic lkp_ready, res_valid, res_hit;
    logic [RESP_W-1:0] res_resp;
    logic mgmt_req = 1'b0, mgmt_op = 1'b0;
    logic [KEY_W-1:0] mgmt_key = '0;
    logic [RESP_W-1:0] mgmt_resp = '0;
    logic mgmt_ready, mgmt_done;
    logic [1:0] mgmt_status;

    int n_chk = 0;
    int n_err = 0;

    logic              mv [BUCKETS][WAYS];
    logic [KEY_W-1:0]  mk [BUCKETS][WAYS];
    logic [RESP_W-1:0] mr [BUCKETS][WAYS];

    always #(CLK_P/2) clk = ~clk;

    hash_lut #(.KEY_W(KEY_W), .RESP_W(RESP_W), .DEPTH(DEPTH), .WAYS(WAYS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_key(lkp_key), .lkp_ready(lkp_ready),
        .res_valid(res_valid), .res_hit(res_hit), .res_resp(res_resp),
        .mgmt_req(mgmt_req), .mgmt_op(mgmt_op), .mgmt_key(mgmt_key),
        .mgmt_resp(mgmt_resp), .mgmt_ready(mgmt_ready), .mgmt_done(mgmt_done),
        .mgmt_status(mgmt_status));

    // R10: 6-bit XOR fold
    function automatic int bucket_of(logic [KEY_W-1:0] k);
        return int'(k[5:0] ^ k[11:6] ^ {2'b00, k[15:12]});
    endfunction

    function automatic logic [1:0] model_apply(logic op, logic [KEY_W-1:0] k,
                                               logic [RESP_W-1:0] r);
        int b = bucket_of(k);
        for (int w = 0; w < WAYS; w++) begin
            if (mv[b][w] && mk[b][w] == k) begin
                if (op == 1'b0) begin mr[b][w] = r; return 2'd1; end
                mv[b][w] = 1'b0; return 2'd2;
            end
        end
        if (op == 1'b1) return 2'd3;
        for (int w = 0; w < WAYS; w++) begin
            if (!mv[b][w]) begin
                mv[b][w] = 1'b1; mk[b][w] = k; mr[b][w] = r; return 2'd0;
            end
        end
        return 2'd3;
    endfunction

    function automatic logic [RESP_W:0] model_look(logic [KEY_W-1:0] k);
        int b = bucket_of(k);
        for (int w = 0; w < WAYS; w++)
            if (mv[b][w] && mk[b][w] == k) return {1'b1, mr[b][w]};
        return '0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_mgmt(logic op, logic [KEY_W-1:0] k, logic [RESP_W-1:0] r,
                           string req);
        logic [1:0] exp_sts;
        @(negedge clk);
        chk("R9", "ready before request", 32'(mgmt_ready), 32'd1);
        mgmt_req = 1'b1; mgmt_op = op; mgmt_key = k; mgmt_resp = r;
        @(negedge clk);
        mgmt_req = 1'b0;
        chk("R9", "ready after accept", 32'(mgmt_ready), 32'd0);
        @(negedge clk);
        chk("R11", "lookup blocked in write cycle", 32'(lkp_ready), 32'd0);
        @(negedge clk);
        chk("R9", "done pulse", 32'(mgmt_done), 32'd1);
        exp_sts = model_apply(op, k, r);
        chk(req, "status", 32'(mgmt_status), 32'(exp_sts));
        @(negedge clk);
        chk("R9", "done one cycle", 32'(mgmt_done), 32'd0);
    endtask

    task automatic run_lookups(int n, bit from_model);
        logic [KEY_W-1:0] q [32];
        logic [RESP_W:0]  e [32];
        for (int i = 0; i <= n + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                if (i - 3 < n) begin
                    chk("R2", "result valid", 32'(res_valid), 32'd1);
                    chk("R3", "hit flag", 32'(res_hit), 32'(e[i-3][RESP_W]));
                    chk("R3", "response", 32'(res_resp), 32'(e[i-3][RESP_W-1:0]));
                end else begin
                    chk("R2", "no result without request", 32'(res_valid), 32'd0);
                end
            end
            if (i < n) begin
                q[i] = 16'($urandom_range(0, 511));
                if (from_model && ($urandom_range(0, 1) == 1)) begin
                    int b = $urandom_range(0, BUCKETS - 1);
                    for (int w = 0; w < WAYS; w++)
                        if (mv[b][w]) q[i] = mk[b][w];
                end
                e[i] = model_look(q[i]);
                lkp_valid = 1'b1; lkp_key = q[i];
            end else begin
                lkp_valid = 1'b0;
            end
        end
    endtask

    task automatic single_lookup(logic [KEY_W-1:0] k, string req);
        logic [RESP_W:0] e = model_look(k);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_key = k;
        @(negedge clk);
        lkp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(req, "lookup valid", 32'(res_valid), 32'd1);
        chk(req, "lookup hit", 32'(res_hit), 32'(e[RESP_W]));
        chk(req, "lookup resp", 32'(res_resp), 32'(e[RESP_W-1:0]));
    endtask

    function automatic logic [KEY_W-1:0] same_bucket_key(int m);
        logic [5:0] s = 6'(m);
        return 16'hB000 ^ {4'h0, s, 6'h00} ^ {10'h000, s};
    endfunction

    initial begin
        #(CLK_P * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int cycles;
        void'($urandom(32'd20240611));
        for (int b = 0; b < BUCKETS; b++)
            for (int w = 0; w < WAYS; w++) begin
                mv[b][w] = 1'b0; mk[b][w] = '0; mr[b][w] = '0;
            end

        // R1: reset and sweep
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "res_valid after reset", 32'(res_valid), 32'd0);
        chk("R1", "mgmt_ready during sweep", 32'(mgmt_ready), 32'd0);
        chk("R1", "lkp_ready during sweep", 32'(lkp_ready), 32'd0);
        cycles = 1;
        while (!mgmt_ready && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
        chk("R1", "sweep length", 32'(cycles), 32'(BUCKETS));
        run_lookups(12, 1'b0);   // R1: empty table misses

        // R4, R3
        do_mgmt(1'b0, 16'h1234, 8'h5A, "R4");
        single_lookup(16'h1234, "R3");
        // R5
        do_mgmt(1'b0, 16'h1234, 8'h77, "R5");
        single_lookup(16'h1234, "R5");
        // R7, R5 no duplicate
        do_mgmt(1'b1, 16'h1234, 8'h00, "R7");
        single_lookup(16'h1234, "R7");

        // R6, R10: fill one bucket
        for (int m = 1; m <= 4; m++)
            do_mgmt(1'b0, same_bucket_key(m), 8'(8'h10 + m), "R10");
        do_mgmt(1'b0, same_bucket_key(5), 8'h99, "R6");
        for (int m = 1; m <= 5; m++) single_lookup(same_bucket_key(m), "R6");
        // R8
        do_mgmt(1'b1, same_bucket_key(6), 8'h00, "R8");
        for (int m = 1; m <= 4; m++) single_lookup(same_bucket_key(m), "R8");
        // R4: reuse freed way
        do_mgmt(1'b1, same_bucket_key(2), 8'h00, "R7");
        do_mgmt(1'b0, same_bucket_key(5), 8'h55, "R4");
        single_lookup(same_bucket_key(5), "R4");

        // R11 and R9: blocked lookup, then lookup right after done
        @(negedge clk);
        mgmt_req = 1'b1; mgmt_op = 1'b0; mgmt_key = 16'hC0DE; mgmt_resp = 8'hE7;
        @(negedge clk);
        mgmt_req = 1'b0;
        @(negedge clk);
        chk("R11", "lkp_ready in write cycle", 32'(lkp_ready), 32'd0);
        lkp_valid = 1'b1; lkp_key = 16'hC0DE;
        @(negedge clk);
        chk("R9", "done", 32'(mgmt_done), 32'd1);
        chk("R4", "status added", 32'(mgmt_status), 32'(model_apply(1'b0, 16'hC0DE, 8'hE7)));
        @(negedge clk);
        lkp_valid = 1'b0;
        @(negedge clk);
        chk("R11", "blocked lookup gives no result", 32'(res_valid), 32'd0);
        @(negedge clk);
        chk("R9", "lookup after done valid", 32'(res_valid), 32'd1);
        chk("R9", "lookup after done hit", 32'(res_hit), 32'd1);
        chk("R9", "lookup after done resp", 32'(res_resp), 32'hE7);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic op = ($urandom_range(0, 2) == 0);
            logic [KEY_W-1:0] k = 16'($urandom_range(0, 511));
            do_mgmt(op, k, 8'($urandom), op ? "R7" : "R4");
            if (i % 25 == 24) run_lookups(16, 1'b1);
        end
        run_lookups(24, 1'b1);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule